// File: doc/BRIEF.md
# Four-Bit Selectable Arithmetic/Logic Function Slice

This block is a slice of an arithmetic logic unit, four bits wide by default, that returns one of sixteen bitwise logic functions or one of sixteen arithmetic functions of two operands. A four-bit function code and a mode bit choose the operation. With the mode bit high, internal carries play no part and the result is a pure bitwise function. With it low, every arithmetic operation has the form "A plus a term built from A and B", plus an optional carry of one.

Operands and results are active-high. The carry input and carry output are active-low, and so are the group propagate and group generate summaries, which a lookahead unit above the slice can use to chain wider words. An equality flag reports an all-ones result. In subtract mode this flag shows that the operands are equal, and the carry output gives their relative magnitude. The outputs pass through a register stage when the `REG_OUT` parameter is 1 (the default). With it at 0 the slice is purely combinational.

Top module: `fgen_alu`

## Requirements
- R1: With modeLogic=1 the result is a bitwise function picked by fnSel: 0000 gives NOT A, 0001 NOR, 0010 (NOT A) AND B, 0011 all zeros, 0100 NAND, 0101 NOT B, 0110 XOR, 0111 A AND NOT B, 1000 (NOT A) OR B, 1001 XNOR, 1010 B, 1011 AND, 1100 all ones, 1101 A OR NOT B, 1110 OR, 1111 A.
- R2: With modeLogic=0 and carryInN=1, result = A + W mod 16, where W is chosen by fnSel: 0000 gives 0, 0001 ~A&B, 0010 ~A&~B, 0011 ~A (result all ones), 0100 A&~B, 0101 A^B, 0110 ~B, 0111 ~(A&B), 1000 A&B, 1001 B, 1010 ~(A^B), 1011 ~A|B, 1100 A (shift left by one), 1101 A|B, 1110 A|~B, 1111 all ones (A minus 1).
- R3: With modeLogic=0 and carryInN=0, the result is the R2 value plus one, mod 16.
- R4: fnSel=0110 in arithmetic mode gives A−B−1 when carryInN=1 and A−B when carryInN=0.
- R5: carryOutN is the inverted carry out of A + W + (NOT carryInN), in both modes. In subtract mode with carryInN=1 it is high exactly when A ≤ B. With carryInN=0 it is high exactly when A < B.
- R6: aEqB is high exactly when every result bit is 1. In subtract mode with carryInN=1 this happens exactly when A equals B.
- R7: propN is low exactly when (A|W) is all ones. genN is low exactly when A + W with no carry-in carries out of the top bit.
- R8: With REG_OUT=1 the outputs change only at a rising clock edge and reflect the inputs present at that edge. While rstN is low the outputs hold result=0, carryOutN=1, propN=1, genN=1 and aEqB=0.
- R9: In logic mode the result does not depend on carryInN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rstN | input | 1 | Asynchronous active-low reset of the output register stage |
| opA | input | 4 | Operand A |
| opB | input | 4 | Operand B |
| fnSel | input | 4 | Function code |
| modeLogic | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| carryInN | input | 1 | Active-low carry input |
| result | output | 4 | Function result |
| carryOutN | output | 1 | Active-low carry output |
| propN | output | 1 | Active-low group propagate |
| genN | output | 1 | Active-low group generate |
| aEqB | output | 1 | High when every result bit is 1 |

## Verification
The bench builds the slice with the default width of 4 and `REG_OUT=1`. The input space is only 14 bits at this width, so every combination of operands, function code, mode and carry is applied once, and all five outputs are compared with a model that works only from the function tables. The registered option also puts the one-cycle latency, and the reset values forced while inputs are non-zero, within reach of directed checks.

// File: rtl/fgen_alu_pkg.sv
package fgen_alu_pkg;

  // Strobes from the function decoder to the datapath
  typedef struct packed {
    logic arithEn;   // let carries reach the result bits
    logic carryIn;   // true-polarity carry into bit 0
    logic propB;     // propagate term includes B
    logic propNotB;  // propagate term includes NOT B
    logic genAB;     // generate term includes A AND B
    logic genANotB;  // generate term includes A AND NOT B
  } aluStrobes_t;

endpackage

// File: rtl/fgen_alu_ctrl.sv
module fgen_alu_ctrl
  import fgen_alu_pkg::*;
(
  input  logic [3:0]  fnSel,
  input  logic        modeLogic,
  input  logic        carryInN,
  output aluStrobes_t strb
);

  always_comb begin
    strb.arithEn  = ~modeLogic;
    strb.carryIn  = ~carryInN;
    strb.propB    = fnSel[0];
    strb.propNotB = fnSel[1];
    strb.genANotB = fnSel[2];
    strb.genAB    = fnSel[3];
  end

endmodule

// File: rtl/fgen_alu_datapath.sv
module fgen_alu_datapath
  import fgen_alu_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  aluStrobes_t   strb,
  output logic [DW-1:0] fNext,
  output logic          coutNNext,
  output logic          propNNext,
  output logic          genNNext,
  output logic          eqNext
);

  logic [DW-1:0] bitProp;
  logic [DW-1:0] bitGen;
  logic [DW:0]   carryChain;
  logic [DW:0]   genChain;

  // Per-bit propagate and generate terms picked by the strobes
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign bitProp[i] = opA[i] | (strb.propB & opB[i]) | (strb.propNotB & ~opB[i]);
    assign bitGen[i]  = (strb.genAB & opA[i] & opB[i]) | (strb.genANotB & opA[i] & ~opB[i]);
    assign carryChain[i+1] = bitGen[i] | (bitProp[i] & carryChain[i]);
    assign genChain[i+1]   = bitGen[i] | (bitProp[i] & genChain[i]);
    // Logic mode: inverted half sum; arithmetic mode: full sum
    assign fNext[i] = strb.arithEn ? (bitProp[i] ^ bitGen[i] ^ carryChain[i])
                                   : ~(bitProp[i] ^ bitGen[i]);
  end

  assign carryChain[0] = strb.carryIn;
  assign genChain[0]   = 1'b0;

  assign coutNNext = ~carryChain[DW];
  assign propNNext = ~(&bitProp);
  assign genNNext  = ~genChain[DW];
  assign eqNext    = &fNext;

endmodule

// File: rtl/fgen_alu_outstage.sv
module fgen_alu_outstage #(
  parameter int DW      = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] fNext,
  input  logic          coutNNext,
  input  logic          propNNext,
  input  logic          genNNext,
  input  logic          eqNext,
  output logic [DW-1:0] result,
  output logic          carryOutN,
  output logic          propN,
  output logic          genN,
  output logic          aEqB
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        result    <= '0;
        carryOutN <= 1'b1;
        propN     <= 1'b1;
        genN      <= 1'b1;
        aEqB      <= 1'b0;
      end else begin
        result    <= fNext;
        carryOutN <= coutNNext;
        propN     <= propNNext;
        genN      <= genNNext;
        aEqB      <= eqNext;
      end
    end
  end else begin : g_comb
    assign result    = fNext;
    assign carryOutN = coutNNext;
    assign propN     = propNNext;
    assign genN      = genNNext;
    assign aEqB      = eqNext;
  end

endmodule

// File: rtl/fgen_alu.sv
module fgen_alu
  import fgen_alu_pkg::*;
#(
  parameter int DW      = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic [3:0]    fnSel,
  input  logic          modeLogic,
  input  logic          carryInN,
  output logic [DW-1:0] result,
  output logic          carryOutN,
  output logic          propN,
  output logic          genN,
  output logic          aEqB
);

  aluStrobes_t   strb;
  logic [DW-1:0] fNext;
  logic          coutNNext;
  logic          propNNext;
  logic          genNNext;
  logic          eqNext;

  fgen_alu_ctrl u_ctrl (
    .fnSel     (fnSel),
    .modeLogic (modeLogic),
    .carryInN  (carryInN),
    .strb      (strb)
  );

  fgen_alu_datapath #(.DW(DW)) u_dp (
    .opA       (opA),
    .opB       (opB),
    .strb      (strb),
    .fNext     (fNext),
    .coutNNext (coutNNext),
    .propNNext (propNNext),
    .genNNext  (genNNext),
    .eqNext    (eqNext)
  );

  fgen_alu_outstage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rstN      (rstN),
    .fNext     (fNext),
    .coutNNext (coutNNext),
    .propNNext (propNNext),
    .genNNext  (genNNext),
    .eqNext    (eqNext),
    .result    (result),
    .carryOutN (carryOutN),
    .propN     (propN),
    .genN      (genN),
    .aEqB      (aEqB)
  );

endmodule

// File: rtl/fgen_alu_checker.sv
module fgen_alu_checker #(
  parameter int DW      = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rstN,
  input logic [DW-1:0] opA,
  input logic [DW-1:0] opB,
  input logic [3:0]    fnSel,
  input logic          modeLogic,
  input logic          carryInN,
  input logic [DW-1:0] result,
  input logic          carryOutN,
  input logic          propN,
  input logic          genN,
  input logic          aEqB
);

  logic [DW-1:0] capA, capB;
  logic [3:0]    capS;
  logic          capM, capCn;
  logic          armed;

  always_ff @(posedge clk) begin
    capA  <= opA;
    capB  <= opB;
    capS  <= fnSel;
    capM  <= modeLogic;
    capCn <= carryInN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // Inputs that the current outputs belong to
  logic [DW-1:0] inA, inB;
  logic [3:0]    inS;
  logic          inM, inCn;
  assign inA  = REG_OUT ? capA  : opA;
  assign inB  = REG_OUT ? capB  : opB;
  assign inS  = REG_OUT ? capS  : fnSel;
  assign inM  = REG_OUT ? capM  : modeLogic;
  assign inCn = REG_OUT ? capCn : carryInN;

  AST_LOGIC_PASS_A: assert property (@(posedge clk) disable iff (!rstN)
    (armed && inM && inS == 4'b1111) |-> (result == inA)); // R1

  AST_ADD_WITH_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !inM && inS == 4'b1001) |-> (result == DW'(inA + inB + DW'(!inCn)))); // R3

  AST_SUB_MAGNITUDE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !inM && inS == 4'b0110 && inCn) |-> (carryOutN == (inA <= inB))); // R5

  AST_EQ_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (aEqB == (&result))); // R6

  AST_PROP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (armed && inS == 4'b0011) |-> !propN); // R7

  AST_GEN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (armed && inS == 4'b1100) |-> (genN == !inA[DW-1])); // R7

endmodule

bind fgen_alu fgen_alu_checker #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opA       (opA),
  .opB       (opB),
  .fnSel     (fnSel),
  .modeLogic (modeLogic),
  .carryInN  (carryInN),
  .result    (result),
  .carryOutN (carryOutN),
  .propN     (propN),
  .genN      (genN),
  .aEqB      (aEqB)
);

// File: tb/fgen_alu_tb.sv
module fgen_alu_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic [3:0] opA = '0, opB = '0, fnSel = '0;
  logic       modeLogic = 1'b0, carryInN = 1'b1;
  logic [3:0] result;
  logic       carryOutN, propN, genN, aEqB;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  fgen_alu u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .fnSel(fnSel),
    .modeLogic(modeLogic), .carryInN(carryInN), .result(result),
    .carryOutN(carryOutN), .propN(propN), .genN(genN), .aEqB(aEqB)
  );

  // Second operand W of the arithmetic form A + W (R2)
  function automatic logic [3:0] wTerm(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
    case (s)
      4'd0:  return 4'h0;
      4'd1:  return ~a & b;
      4'd2:  return ~a & ~b;
      4'd3:  return ~a;
      4'd4:  return a & ~b;
      4'd5:  return a ^ b;
      4'd6:  return ~b;
      4'd7:  return ~(a & b);
      4'd8:  return a & b;
      4'd9:  return b;
      4'd10: return ~(a ^ b);
      4'd11: return ~a | b;
      4'd12: return a;
      4'd13: return a | b;
      4'd14: return a | ~b;
      default: return 4'hF;
    endcase
  endfunction

  // Bitwise functions of R1
  function automatic logic [3:0] logicFn(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
    case (s)
      4'd0:  return ~a;
      4'd1:  return ~(a | b);
      4'd2:  return ~a & b;
      4'd3:  return 4'h0;
      4'd4:  return ~(a & b);
      4'd5:  return ~b;
      4'd6:  return a ^ b;
      4'd7:  return a & ~b;
      4'd8:  return ~a | b;
      4'd9:  return ~(a ^ b);
      4'd10: return b;
      4'd11: return a & b;
      4'd12: return 4'hF;
      4'd13: return a | ~b;
      4'd14: return a | b;
      default: return a;
    endcase
  endfunction

  // Packed expectation {f[3:0], coutN, propN, genN, eq}
  function automatic logic [7:0] model(input logic m, input logic [3:0] s, input logic cn,
                                       input logic [3:0] a, input logic [3:0] b);
    logic [3:0] w, f;
    logic [4:0] sum, sum0;
    w    = wTerm(s, a, b);
    sum  = {1'b0, a} + {1'b0, w} + {4'b0, ~cn};
    sum0 = {1'b0, a} + {1'b0, w};
    f    = m ? logicFn(s, a, b) : sum[3:0];
    return {f, ~sum[4], ~(&(a | w)), ~sum0[4], &f};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {f,co,p,g,eq}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {result, carryOutN, propN, genN, aEqB};
  endfunction

  task automatic apply(input logic m, input logic [3:0] s, input logic cn,
                       input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    modeLogic = m; fnSel = s; carryInN = cn; opA = a; opB = b;
    @(posedge clk);
    #2;
  endtask

  // Directed vectors: {m, s[3:0], cn, a[3:0], b[3:0], f[3:0], coutN, eq}
  localparam int NVEC = 10;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 4'd6,  1'b1, 4'd5,  4'd3, 4'd6,  1'b0, 1'b0},  // R1 XOR
    {1'b0, 4'd9,  1'b1, 4'd9,  4'd8, 4'd1,  1'b0, 1'b0},  // R2 add, overflow
    {1'b0, 4'd9,  1'b0, 4'd7,  4'd8, 4'd0,  1'b0, 1'b0},  // R3 add plus one
    {1'b0, 4'd6,  1'b1, 4'd5,  4'd5, 4'd15, 1'b1, 1'b1},  // R6 equal operands
    {1'b0, 4'd6,  1'b0, 4'd3,  4'd7, 4'd12, 1'b1, 1'b0},  // R4 A-B, A<B
    {1'b0, 4'd12, 1'b1, 4'd9,  4'd0, 4'd2,  1'b0, 1'b0},  // R2 shift left
    {1'b0, 4'd15, 1'b1, 4'd0,  4'd0, 4'd15, 1'b1, 1'b1},  // R2 A minus 1
    {1'b0, 4'd3,  1'b0, 4'd6,  4'd1, 4'd0,  1'b0, 1'b0},  // R3 minus one plus one
    {1'b1, 4'd0,  1'b0, 4'd10, 4'd0, 4'd5,  1'b1, 1'b0},  // R1 NOT A
    {1'b1, 4'd12, 1'b1, 4'd3,  4'd2, 4'd15, 1'b1, 1'b1}   // R1 all ones
  };

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    opA = 4'hF; opB = 4'hF; fnSel = 4'd9; modeLogic = 1'b0; carryInN = 1'b0;
    #5 rstN = 1'b0;
    #30;
    // R8: reset values while inputs would give a non-zero result
    check("R8 reset", outs(), 8'b0000_1110);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [19:0] v;
      logic [7:0]  e;
      v = VEC[i];
      apply(v[19], v[18:15], v[14], v[13:10], v[9:6]);
      e = model(v[19], v[18:15], v[14], v[13:10], v[9:6]);
      check("R1-table", {result, carryOutN, aEqB}, {v[5:2], v[1], v[0]});
      check("R7 table", {propN, genN}, e[2:1]);
    end

    // R4: A - B with carry asserted, A > B
    apply(1'b0, 4'd6, 1'b0, 4'd9, 4'd4);
    check("R4 sub", {result, carryOutN}, {4'd5, 1'b0});
    // R5: carryInN=0, A == B gives carryOutN low (A >= B)
    apply(1'b0, 4'd6, 1'b0, 4'd7, 4'd7);
    check("R5 cmp", {result, carryOutN}, {4'd0, 1'b0});

    // R9: logic mode ignores carry input
    apply(1'b1, 4'd10, 1'b0, 4'd4, 4'd9);
    check("R9 cn0", {4'b0, result}, {4'b0, 4'd9});
    apply(1'b1, 4'd10, 1'b1, 4'd4, 4'd9);
    check("R9 cn1", {4'b0, result}, {4'b0, 4'd9});

    // R8: output holds until the next rising edge
    @(negedge clk);
    modeLogic = 1'b1; fnSel = 4'd3;
    #2;
    check("R8 hold", {4'b0, result}, {4'b0, 4'd9});
    @(posedge clk); #2;
    check("R8 update", {4'b0, result}, 8'd0);

    // Exhaustive sweep of all 2^14 input combinations
    for (int v = 0; v < 16384; v++) begin
      logic [13:0] x;
      x = 14'(v);
      apply(x[12], x[11:8], x[13], x[3:0], x[7:4]);
      check(x[12] ? "R1 sweep" : (x[13] ? "R2 sweep" : "R3 sweep"),
            outs(), model(x[12], x[11:8], x[13], x[3:0], x[7:4]));
    end

    // R8: reset mid-run
    @(negedge clk) rstN = 1'b0;
    #2;
    check("R8 midreset", outs(), 8'b0000_1110);
    @(negedge clk) rstN = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule